// File: doc/BRIEF.md
# Self-triggered hit recorder with bunch-crossing tags

This block sits behind the channel discriminators of a multi-channel front end and keeps a short log of the hits seen during one bunch train. An acquisition window is opened by a start pulse and closed by a stop pulse. While the window is open, a bunch-crossing counter advances once per acquisition clock. In every cycle where at least one trigger line is high, the block claims the next free column of a small event store. That column receives the current bunch-crossing number and the pattern of channels that fired. For each capture the block also emits a one-cycle hold strobe and the column index, so the analog sampling cells of that column can be frozen.

The store fills from column 0 upward. When every column is taken, a full flag rises and later triggers are dropped until a new window starts. At the end of a window that captured nothing, a no-trigger flag is raised. A read port selects any column and returns its tag and hit pattern. It is used for conversion and readout after the window closes.

Top module: `trg_event_recorder`

## Requirements
- R1: After reset, hold_o, full_o and notrig_o are 0, and every column reads back a zero tag and a zero hit pattern.
- R2: An acq_start_i pulse empties the store and clears full_o and notrig_o. Afterwards every column reads zero and the next capture goes to column 0. When acq_start_i and acq_stop_i are high in the same cycle, the start wins and the window is open afterwards.
- R3: While the window is open, the bunch-crossing counter is 0 in the first cycle after the start pulse and rises by one each cycle. It is BC_W bits wide (default 12) and wraps from 4095 to 0. A capture stores the counter value of the cycle in which the triggers were seen.
- R4: In an open window with the store not full, a cycle with any trigger line high writes the next free column. Columns are taken in ascending order from 0. Hit bit i is channel i. In the following cycle hold_o is 1 for exactly one cycle and col_o shows the written column index.
- R5: Several trigger lines high in the same cycle share a single column, with one hit bit set per active channel, and consume only one column.
- R6: full_o is 1 once all DEPTH (default 16) columns are used. Afterwards triggers produce no hold_o and change no stored column, until the next acq_start_i.
- R7: Triggers are ignored when the window is closed. They are also ignored in the cycle where acq_start_i or acq_stop_i is high: no hold_o and no write.
- R8: An acq_stop_i during an open window sets notrig_o to 1 if no column was written in that window, and to 0 otherwise. The flag keeps its value until the next acq_start_i.
- R9: rd_col_i selects a column, and rd_bcid_o and rd_hits_o show its stored tag and hit pattern in the same cycle. Columns not written since the last start read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Acquisition clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_start_i | input | 1 | Opens a window, clears store and counter |
| acq_stop_i | input | 1 | Closes the window |
| trig_i | input | N_CH | Channel discriminator outputs, bit i = channel i |
| rd_col_i | input | log2(DEPTH) | Column selected for readback |
| hold_o | output | 1 | One-cycle strobe per capture |
| col_o | output | log2(DEPTH) | Column written by the last capture |
| full_o | output | 1 | All columns used |
| notrig_o | output | 1 | Last window captured nothing |
| rd_bcid_o | output | BC_W | Tag of the selected column |
| rd_hits_o | output | N_CH | Hit pattern of the selected column |

## Verification
The bench builds the block with its defaults: 36 channels, 16 columns and a 12-bit counter. This puts both ends of the hit pattern (channel 0 and channel 35) and the full-store boundary at column 15 directly under test. The 12-bit counter wraps after 4096 cycles, so the bench can hold a window open past the wrap and check a tag taken just after it. Collisions of triggers with the start or stop cycle are driven on purpose.

// File: rtl/trg_rec_pkg.sv
package trg_rec_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } acq_phase_t;
endpackage

// File: rtl/trg_bc_counter.sv
module trg_bc_counter #(
   parameter int BC_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            run_i,
   output logic [BC_W-1:0] bc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bc_o <= '0;
      else if (clear_i) bc_o <= '0;
      else if (run_i)   bc_o <= bc_o + 1'b1;
   end
endmodule

// File: rtl/trg_col_alloc.sv
module trg_col_alloc
   import trg_rec_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     stop_i,
   input  logic                     any_trig_i,
   output logic                     run_o,
   output logic                     wr_en_o,
   output logic [$clog2(DEPTH)-1:0] wr_col_o,
   output logic                     hold_o,
   output logic [$clog2(DEPTH)-1:0] col_o,
   output logic                     full_o,
   output logic                     notrig_o
);
   localparam int COL_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   acq_phase_t       phase_q;
   logic [CNT_W-1:0] used_q;

   assign run_o    = (phase_q == PH_RUN);
   assign full_o   = (used_q == CNT_W'(DEPTH));
   assign wr_col_o = used_q[COL_W-1:0];
   assign wr_en_o  = run_o && !start_i && !stop_i && any_trig_i && !full_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         used_q   <= '0;
         hold_o   <= 1'b0;
         col_o    <= '0;
         notrig_o <= 1'b0;
      end else if (start_i) begin
         phase_q  <= PH_RUN;
         used_q   <= '0;
         hold_o   <= 1'b0;
         notrig_o <= 1'b0;
      end else begin
         hold_o <= wr_en_o;
         if (wr_en_o) begin
            col_o  <= wr_col_o;
            used_q <= used_q + 1'b1;
         end
         if (stop_i && run_o) begin
            phase_q  <= PH_IDLE;
            notrig_o <= (used_q == '0);
         end
      end
   end
endmodule

// File: rtl/trg_tag_store.sv
module trg_tag_store #(
   parameter int N_CH  = 36,
   parameter int DEPTH = 16,
   parameter int BC_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_i,
   input  logic                     wr_en_i,
   input  logic [$clog2(DEPTH)-1:0] wr_col_i,
   input  logic [BC_W-1:0]          bc_i,
   input  logic [N_CH-1:0]          hits_i,
   input  logic [$clog2(DEPTH)-1:0] rd_col_i,
   output logic [BC_W-1:0]          rd_bcid_o,
   output logic [N_CH-1:0]          rd_hits_o
);
   localparam int COL_W = $clog2(DEPTH);

   logic [DEPTH-1:0][BC_W-1:0] bcid_all;
   logic [DEPTH-1:0][N_CH-1:0] hits_all;

   for (genvar c = 0; c < DEPTH; c++) begin : g_col
      logic [BC_W-1:0] bcid_q;
      logic [N_CH-1:0] hits_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bcid_q <= '0;
            hits_q <= '0;
         end else if (clear_i) begin
            bcid_q <= '0;
            hits_q <= '0;
         end else if (wr_en_i && (wr_col_i == COL_W'(c))) begin
            bcid_q <= bc_i;
            hits_q <= hits_i;
         end
      end
      assign bcid_all[c] = bcid_q;
      assign hits_all[c] = hits_q;
   end

   assign rd_bcid_o = bcid_all[rd_col_i];
   assign rd_hits_o = hits_all[rd_col_i];
endmodule

// File: rtl/trg_event_recorder.sv
module trg_event_recorder #(
   parameter int N_CH  = 36,
   parameter int DEPTH = 16,
   parameter int BC_W  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acq_start_i,
   input  logic                     acq_stop_i,
   input  logic [N_CH-1:0]          trig_i,
   input  logic [$clog2(DEPTH)-1:0] rd_col_i,
   output logic                     hold_o,
   output logic [$clog2(DEPTH)-1:0] col_o,
   output logic                     full_o,
   output logic                     notrig_o,
   output logic [BC_W-1:0]          rd_bcid_o,
   output logic [N_CH-1:0]          rd_hits_o
);
   localparam int COL_W = $clog2(DEPTH);

   if (N_CH < 1) begin : g_bad_nch
      $error("N_CH must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BC_W < 2) begin : g_bad_bcw
      $error("BC_W must be at least 2");
   end

   logic             run;
   logic             wr_en;
   logic [COL_W-1:0] wr_col;
   logic [BC_W-1:0]  bc;

   trg_bc_counter #(.BC_W(BC_W)) u_bc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (acq_start_i),
      .run_i   (run),
      .bc_o    (bc)
   );

   trg_col_alloc #(.DEPTH(DEPTH)) u_alloc (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (acq_start_i),
      .stop_i     (acq_stop_i),
      .any_trig_i (|trig_i),
      .run_o      (run),
      .wr_en_o    (wr_en),
      .wr_col_o   (wr_col),
      .hold_o     (hold_o),
      .col_o      (col_o),
      .full_o     (full_o),
      .notrig_o   (notrig_o)
   );

   trg_tag_store #(.N_CH(N_CH), .DEPTH(DEPTH), .BC_W(BC_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (acq_start_i),
      .wr_en_i   (wr_en),
      .wr_col_i  (wr_col),
      .bc_i      (bc),
      .hits_i    (trig_i),
      .rd_col_i  (rd_col_i),
      .rd_bcid_o (rd_bcid_o),
      .rd_hits_o (rd_hits_o)
   );
endmodule

// File: rtl/trg_event_recorder_chk.sv
module trg_event_recorder_chk #(
   parameter int N_CH  = 36,
   parameter int DEPTH = 16,
   parameter int BC_W  = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     acq_start_i,
   input logic                     acq_stop_i,
   input logic [N_CH-1:0]          trig_i,
   input logic                     hold_o,
   input logic [$clog2(DEPTH)-1:0] col_o,
   input logic                     full_o,
   input logic                     notrig_o
);
   localparam int COL_W = $clog2(DEPTH);

   // R2
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      acq_start_i |=> (!full_o && !notrig_o && !hold_o));

   // R4
   a_r4_hold_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> $past(|trig_i));

   // R4
   a_r4_columns_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_o && $past(hold_o)) |-> (col_o == COL_W'($past(col_o) + 1'b1)));

   // R6
   a_r6_no_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !acq_start_i) |=> !hold_o);

   // R6
   a_r6_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !acq_start_i) |=> full_o);

   // R7
   a_r7_no_hold_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_start_i || acq_stop_i) |=> !hold_o);

   // R8
   a_r8_notrig_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!acq_start_i && !acq_stop_i) |=> $stable(notrig_o));
endmodule

bind trg_event_recorder trg_event_recorder_chk #(
   .N_CH(N_CH), .DEPTH(DEPTH), .BC_W(BC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acq_start_i (acq_start_i),
   .acq_stop_i  (acq_stop_i),
   .trig_i      (trig_i),
   .hold_o      (hold_o),
   .col_o       (col_o),
   .full_o      (full_o),
   .notrig_o    (notrig_o)
);

// File: tb/trg_event_recorder_test.sv
`timescale 1ns/1ps
module trg_event_recorder_test;
   localparam int N_CH  = 36;
   localparam int DEPTH = 16;
   localparam int BC_W  = 12;
   localparam int COL_W = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acq_start_i = 1'b0;
   logic             acq_stop_i = 1'b0;
   logic [N_CH-1:0]  trig_i = '0;
   logic [COL_W-1:0] rd_col_i = '0;
   logic             hold_o;
   logic [COL_W-1:0] col_o;
   logic             full_o;
   logic             notrig_o;
   logic [BC_W-1:0]  rd_bcid_o;
   logic [N_CH-1:0]  rd_hits_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the bunch-crossing count (R3)
   logic [BC_W-1:0] exp_bc = '0;
   bit              exp_run = 1'b0;

   trg_event_recorder #(.N_CH(N_CH), .DEPTH(DEPTH), .BC_W(BC_W)) uut (
      .clk(clk), .rst_n(rst_n), .acq_start_i(acq_start_i), .acq_stop_i(acq_stop_i),
      .trig_i(trig_i), .rd_col_i(rd_col_i), .hold_o(hold_o), .col_o(col_o),
      .full_o(full_o), .notrig_o(notrig_o), .rd_bcid_o(rd_bcid_o), .rd_hits_o(rd_hits_o)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_bc  <= '0;
         exp_run <= 1'b0;
      end else if (acq_start_i) begin
         exp_bc  <= '0;
         exp_run <= 1'b1;
      end else begin
         if (exp_run) exp_bc <= exp_bc + 1'b1;
         if (acq_stop_i) exp_run <= 1'b0;
      end
   end

   task automatic check_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic start_acq();
      acq_start_i = 1'b1;
      @(negedge clk);
      acq_start_i = 1'b0;
   endtask

   task automatic stop_acq();
      acq_stop_i = 1'b1;
      @(negedge clk);
      acq_stop_i = 1'b0;
   endtask

   task automatic fire(input logic [N_CH-1:0] pat);
      trig_i = pat;
      @(negedge clk);
      trig_i = '0;
   endtask

   task automatic read_col(input int c, output logic [BC_W-1:0] b, output logic [N_CH-1:0] h);
      rd_col_i = COL_W'(c);
      #1;
      b = rd_bcid_o;
      h = rd_hits_o;
   endtask

   task automatic t_reset();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      check_eq("R1", "hold after reset", hold_o, 0);
      check_eq("R1", "full after reset", full_o, 0);
      check_eq("R1", "notrig after reset", notrig_o, 0);
      read_col(7, b, h);
      check_eq("R1", "col7 tag after reset", b, 0);
      check_eq("R1", "col7 hits after reset", h, 0);
   endtask

   task automatic t_idle_ignored();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      fire('hFF);
      check_eq("R7", "hold while closed", hold_o, 0);
      read_col(0, b, h);
      check_eq("R7", "col0 hits while closed", h, 0);
   endtask

   task automatic t_single();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      logic [BC_W-1:0] seen;
      start_acq();
      cyc(3);
      seen = exp_bc;
      fire(N_CH'(1) << 5);
      check_eq("R4", "hold after first hit", hold_o, 1);
      check_eq("R4", "col of first hit", col_o, 0);
      read_col(0, b, h);
      check_eq("R3", "tag of first hit", b, 3);
      check_eq("R3", "tag vs model", b, seen);
      check_eq("R4", "hits of first hit", h, N_CH'(1) << 5);
      cyc(1);
      check_eq("R4", "hold lasts one cycle", hold_o, 0);
   endtask

   task automatic t_multi();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      logic [N_CH-1:0] pat;
      pat = (N_CH'(1) << 35) | N_CH'(1);
      fire(pat);
      check_eq("R5", "col of shared hit", col_o, 1);
      read_col(1, b, h);
      check_eq("R5", "shared hit pattern", h, pat);
      fire(N_CH'(1) << 17);
      check_eq("R5", "one column consumed", col_o, 2);
   endtask

   task automatic t_full();
      logic [BC_W-1:0] b15;
      logic [N_CH-1:0] h;
      logic [BC_W-1:0] b;
      for (int k = 3; k < DEPTH; k++) fire(N_CH'(1) << k);
      check_eq("R6", "full after last column", full_o, 1);
      check_eq("R4", "last column index", col_o, DEPTH - 1);
      read_col(15, b15, h);
      check_eq("R4", "col15 hits", h, N_CH'(1) << 15);
      fire('1);
      check_eq("R6", "no hold when full", hold_o, 0);
      check_eq("R6", "full sticks", full_o, 1);
      read_col(15, b, h);
      check_eq("R6", "col15 hits unchanged", h, N_CH'(1) << 15);
      check_eq("R6", "col15 tag unchanged", b, b15);
      stop_acq();
      check_eq("R8", "notrig after busy window", notrig_o, 0);
   endtask

   task automatic t_restart_and_stop_cycle();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      start_acq();
      check_eq("R2", "full cleared by start", full_o, 0);
      read_col(0, b, h);
      check_eq("R2", "col0 hits cleared", h, 0);
      check_eq("R2", "col0 tag cleared", b, 0);
      trig_i = '1;
      acq_stop_i = 1'b1;
      @(negedge clk);
      trig_i = '0;
      acq_stop_i = 1'b0;
      check_eq("R7", "no hold in stop cycle", hold_o, 0);
      check_eq("R8", "notrig after empty window", notrig_o, 1);
      fire('1);
      check_eq("R8", "notrig holds while closed", notrig_o, 1);
      read_col(0, b, h);
      check_eq("R9", "unwritten col reads zero", h, 0);
   endtask

   task automatic t_start_cycle();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      trig_i = N_CH'(1) << 9;
      acq_start_i = 1'b1;
      @(negedge clk);
      trig_i = '0;
      acq_start_i = 1'b0;
      check_eq("R7", "no hold in start cycle", hold_o, 0);
      check_eq("R2", "notrig cleared by start", notrig_o, 0);
      fire(N_CH'(1) << 2);
      check_eq("R2", "first capture in col0", col_o, 0);
      read_col(0, b, h);
      check_eq("R9", "readback of col0 hits", h, N_CH'(1) << 2);
      check_eq("R3", "tag one cycle after start", b, 0);
      stop_acq();
   endtask

   task automatic t_start_beats_stop();
      acq_start_i = 1'b1;
      acq_stop_i  = 1'b1;
      @(negedge clk);
      acq_start_i = 1'b0;
      acq_stop_i  = 1'b0;
      fire(N_CH'(1) << 30);
      check_eq("R2", "start wins over stop", hold_o, 1);
      stop_acq();
   endtask

   task automatic t_wrap();
      logic [BC_W-1:0] b;
      logic [N_CH-1:0] h;
      logic [BC_W-1:0] seen;
      start_acq();
      cyc(4098);
      seen = exp_bc;
      fire(N_CH'(1) << 1);
      read_col(0, b, h);
      check_eq("R3", "tag after wrap", b, 2);
      check_eq("R3", "wrap tag vs model", b, seen);
      stop_acq();
      check_eq("R8", "notrig after wrap window", notrig_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_idle_ignored();
      t_single();
      t_multi();
      t_full();
      t_restart_and_stop_cycle();
      t_start_cycle();
      t_start_beats_stop();
      t_wrap();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule